// File: doc/BRIEF.md
# Scanline Table Transfer Engine

This block runs a per-channel, table-driven register update for a video-timed system. When the frame begins, each channel whose enable bit is set fetches the first line-count byte of its table in memory. After that, every horizontal-line strobe makes each live channel copy its current entry's value bytes into a page of I/O registers. The copy follows the same register-offset patterns that the block-transfer engine uses. When a channel's line counter runs out, the channel fetches the next count byte and moves on to the next entry. A count of zero parks the channel until the next frame.

All channels share one memory read port, and that port moves exactly one byte per cycle. Channels are serviced in ascending order. The host-stall output stays high for every cycle in which a byte is moved. Each channel keeps a 16-bit table pointer and an 8-bit lines-remaining counter. The pointer takes its bank from the upper byte of the channel's source address and wraps inside that bank. Writes always go from memory to I/O, at page 0x21, to the offset the channel's destination byte selects.

Top module: `line_table_engine`

## Requirements
- R1: After reset, mem_rd_o, io_we_o and stall_o are low. A line strobe given before any frame strobe moves no bytes.
- R2: When a frame strobe is accepted, every channel whose bit is set in en_mask_i performs one read, in ascending channel order, at {src[23:16], src[15:0]}. That byte becomes the channel's line count, and its table pointer becomes src[15:0]+1. Channels whose bit is clear become inactive.
- R3: When a line strobe is accepted, every channel that is active and enabled writes its entry's value bytes, in ascending channel order. The number of value bytes comes from the mode field: 000 gives 1, 001 and 010 give 2, 011 and 100 give 4, and 101 to 111 give 1.
- R4: Value byte i goes to io_addr_o = 0x2100 + ((dest + off_i) mod 256). The offsets are {0} for mode 000, {0,1} for mode 001, {0,0} for mode 010, {0,0,1,1} for mode 011 and {0,1,2,3} for mode 100. Modes 101 to 111 use {0}.
- R5: Value byte i is read at {bank, pointer+i}, and io_data_o equals mem_data_i in that same cycle. The same bytes are written again on every line until the entry's count expires.
- R6: After an entry's value writes, the line counter is decremented. When it reaches zero, one read fetches the new count at pointer+n, where n is the entry's value-byte count. The pointer then moves to pointer+n+1.
- R7: A count byte of 0, whether from the frame fetch or from a later fetch, stops all activity for that channel until the next frame strobe.
- R8: Pointer arithmetic wraps at 16 bits, and the bank byte of mem_addr_o does not change.
- R9: stall_o and mem_rd_o are high in exactly those cycles in which a byte is read. No idle cycles occur between channels within one strobe.
- R10: Frame and line strobes that arrive while a strobe is still being serviced are ignored. If both strobes are present while the block is idle, the frame strobe is taken and the line strobe is dropped.
- R11: A channel that is active but whose en_mask_i bit is clear when a line strobe is accepted is skipped for that line, and its table state is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_mask_i | input | N_CH | Per-channel enable for table transfers |
| frame_i | input | 1 | Frame-start strobe |
| line_i | input | 1 | Horizontal-line strobe |
| cfg_mode_i | input | 3*N_CH | Per-channel register pattern mode, channel c at bits [3c+2:3c] |
| cfg_dest_i | input | 8*N_CH | Per-channel I/O register offset within page 0x21 |
| cfg_src_i | input | 24*N_CH | Per-channel table start address, bank in the upper byte |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 24 | Memory read address |
| mem_data_i | input | 8 | Read data, valid in the same cycle as the address |
| io_we_o | output | 1 | I/O register write strobe |
| io_addr_o | output | 16 | I/O register address |
| io_data_o | output | 8 | I/O register write data |
| stall_o | output | 1 | Host stall, high for each byte moved |

## Verification
The hardest state to reach is a four-byte entry whose value bytes straddle the end of a bank. The entry's count byte then has to be fetched from the bottom of the same bank on the very line where another channel is also due for a reload. The bench places one table three bytes below the top of its bank and gives it a one-line first entry, so the wrap and the reload fall on the first line. Other channels with short counts expire on that same strobe. A second line strobe issued mid-service, and a frame strobe raised together with a line strobe, check that neither disturbs the sequence the reference model expects cycle by cycle.

// File: rtl/tbl_pkg.sv
package tbl_pkg;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_FIRST,
    OP_DEC,
    OP_RELOAD
  } chan_op_e;

  // value bytes per entry for a pattern mode
  function automatic logic [2:0] mode_nbytes(input logic [2:0] m);
    case (m)
      3'd1, 3'd2: mode_nbytes = 3'd2;
      3'd3, 3'd4: mode_nbytes = 3'd4;
      default:    mode_nbytes = 3'd1;
    endcase
  endfunction

  // register offset of value byte i
  function automatic logic [1:0] mode_off(input logic [2:0] m, input logic [1:0] i);
    case (m)
      3'd1:    mode_off = {1'b0, i[0]};
      3'd3:    mode_off = {1'b0, i[1]};
      3'd4:    mode_off = i;
      default: mode_off = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/tbl_pick.sv
module tbl_pick #(
  parameter int N  = 8,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [CW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = CW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/tbl_pattern.sv
module tbl_pattern
  import tbl_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [1:0] idx_i,
  output logic [2:0] nb_o,
  output logic [1:0] off_o,
  output logic       last_o
);
  assign nb_o   = mode_nbytes(mode_i);
  assign off_o  = mode_off(mode_i, idx_i);
  assign last_o = (3'({1'b0, idx_i}) + 3'd1) == nb_o;
endmodule

// File: rtl/tbl_chan.sv
module tbl_chan
  import tbl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  chan_op_e    op_i,
  input  logic [7:0]  data_i,
  input  logic [15:0] src_lo_i,
  input  logic [2:0]  nb_i,
  output logic [15:0] ptr_o,
  output logic [7:0]  lines_o,
  output logic        active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o    <= '0;
      lines_o  <= '0;
      active_o <= 1'b0;
    end else if (clr_i) begin
      active_o <= 1'b0;
    end else begin
      case (op_i)
        OP_FIRST: begin
          ptr_o    <= src_lo_i + 16'd1;
          lines_o  <= data_i;
          active_o <= (data_i != 8'd0);
        end
        OP_DEC: lines_o <= lines_o - 8'd1;
        OP_RELOAD: begin
          ptr_o    <= ptr_o + 16'(nb_i) + 16'd1;
          lines_o  <= data_i;
          active_o <= (data_i != 8'd0);
        end
        default: ;
      endcase
    end
  end

  AST_ACTIVE_HAS_LINES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (lines_o != 8'd0)); // R6

  AST_DEC_NOT_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DEC && !clr_i) |=> (lines_o != 8'd0)); // R6
endmodule

// File: rtl/line_table_engine.sv
module line_table_engine
  import tbl_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   en_mask_i,
  input  logic              frame_i,
  input  logic              line_i,
  input  logic [3*N_CH-1:0] cfg_mode_i,
  input  logic [8*N_CH-1:0] cfg_dest_i,
  input  logic [24*N_CH-1:0] cfg_src_i,
  output logic              mem_rd_o,
  output logic [23:0]       mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              io_we_o,
  output logic [15:0]       io_addr_o,
  output logic [7:0]        io_data_o,
  output logic              stall_o
);
  localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;

  logic            busy_q, job_line_q, reload_q;
  logic [1:0]      idx_q;
  logic [N_CH-1:0] pend_q, gnt, act_vec;
  logic [CW-1:0]   cur;
  logic            any;
  logic [15:0]     ptr_a   [N_CH];
  logic [7:0]      lines_a [N_CH];

  tbl_pick #(.N(N_CH), .CW(CW)) u_pick (
    .req_i(pend_q), .gnt_o(gnt), .idx_o(cur), .any_o(any)
  );

  logic [2:0]  mode_cur, nb;
  logic [1:0]  off;
  logic        last;
  logic [7:0]  dest_cur, bank_cur, lines_cur;
  logic [15:0] src_lo_cur, ptr_cur, addr_lo;

  assign mode_cur   = cfg_mode_i[int'(cur)*3 +: 3];
  assign dest_cur   = cfg_dest_i[int'(cur)*8 +: 8];
  assign bank_cur   = cfg_src_i[int'(cur)*24+16 +: 8];
  assign src_lo_cur = cfg_src_i[int'(cur)*24 +: 16];
  assign ptr_cur    = ptr_a[cur];
  assign lines_cur  = lines_a[cur];

  tbl_pattern u_pat (
    .mode_i(mode_cur), .idx_i(idx_q), .nb_o(nb), .off_o(off), .last_o(last)
  );

  logic is_frm, is_val, is_rel, last_line, done, clr;
  chan_op_e op_cur;

  assign is_frm    = busy_q & ~job_line_q;
  assign is_val    = busy_q & job_line_q & ~reload_q;
  assign is_rel    = busy_q & job_line_q & reload_q;
  assign last_line = (lines_cur == 8'd1);
  assign done      = is_frm | is_rel | (is_val & last & ~last_line);
  assign clr       = ~busy_q & frame_i;

  always_comb begin
    if (!job_line_q)   addr_lo = src_lo_cur;
    else if (reload_q) addr_lo = ptr_cur + 16'(nb);
    else               addr_lo = ptr_cur + 16'(idx_q);
  end

  always_comb begin
    if (is_frm)                             op_cur = OP_FIRST;
    else if (is_rel)                        op_cur = OP_RELOAD;
    else if (is_val && last && !last_line)  op_cur = OP_DEC;
    else                                    op_cur = OP_NONE;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    tbl_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr),
      .op_i     (gnt[c] ? op_cur : OP_NONE),
      .data_i   (mem_data_i),
      .src_lo_i (cfg_src_i[c*24 +: 16]),
      .nb_i     (nb),
      .ptr_o    (ptr_a[c]),
      .lines_o  (lines_a[c]),
      .active_o (act_vec[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      job_line_q <= 1'b0;
      reload_q   <= 1'b0;
      idx_q      <= '0;
      pend_q     <= '0;
    end else if (!busy_q) begin
      idx_q    <= '0;
      reload_q <= 1'b0;
      if (frame_i) begin
        job_line_q <= 1'b0;
        pend_q     <= en_mask_i;
        busy_q     <= |en_mask_i;
      end else if (line_i) begin
        job_line_q <= 1'b1;
        pend_q     <= en_mask_i & act_vec;
        busy_q     <= |(en_mask_i & act_vec);
      end
    end else if (done) begin
      pend_q   <= pend_q & ~gnt;
      busy_q   <= |(pend_q & ~gnt);
      reload_q <= 1'b0;
      idx_q    <= '0;
    end else if (is_val && last) begin
      reload_q <= 1'b1;
      idx_q    <= '0;
    end else begin
      idx_q <= idx_q + 2'd1;
    end
  end

  assign mem_rd_o   = busy_q;
  assign stall_o    = busy_q;
  assign mem_addr_o = {bank_cur, addr_lo};
  assign io_we_o    = is_val;
  assign io_addr_o  = {8'h21, dest_cur + 8'(off)};
  assign io_data_o  = mem_data_i;

  AST_BUSY_HAS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (any && $countones(gnt) == 1)); // R9

  AST_PEND_ONLY_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ((pend_q & ~$past(pend_q)) == '0)); // R10

  AST_WRITE_FROM_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_we_o |-> act_vec[cur]); // R7

  AST_BANK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$past(done)) |-> $stable(mem_addr_o[23:16])); // R8
endmodule

// File: tb/line_table_engine_bench.sv
`timescale 1ns/1ps
module line_table_engine_bench;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    en_mask = '0;
  logic            frame = 1'b0, line = 1'b0;
  logic [3*N-1:0]  cfg_mode = '0;
  logic [8*N-1:0]  cfg_dest = '0;
  logic [24*N-1:0] cfg_src = '0;
  logic            mem_rd, io_we, stall;
  logic [23:0]     mem_addr;
  logic [7:0]      mem_data, io_data;
  logic [15:0]     io_addr;

  logic [7:0] mem [0:4095];
  assign mem_data = mem[{mem_addr[15], mem_addr[10:0]}];

  line_table_engine #(.N_CH(N)) u_line_table_engine (
    .clk_i(clk), .rst_ni(rst_n), .en_mask_i(en_mask), .frame_i(frame), .line_i(line),
    .cfg_mode_i(cfg_mode), .cfg_dest_i(cfg_dest), .cfg_src_i(cfg_src),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_data),
    .io_we_o(io_we), .io_addr_o(io_addr), .io_data_o(io_data), .stall_o(stall)
  );

  int checks = 0, fails = 0;

  typedef struct packed {
    logic [1:0]  kind;
    logic        we;
    logic [23:0] a;
    logic [15:0] io;
    logic [7:0]  d;
  } exp_t;
  exp_t q[$];

  int m_ptr [N];
  int m_lines [N];
  bit m_act [N];

  function automatic logic [7:0] rd(input logic [23:0] a);
    return mem[{a[15], a[10:0]}];
  endfunction

  function automatic int nbytes(input int m);
    if (m == 1 || m == 2) return 2;
    if (m == 3 || m == 4) return 4;
    return 1;
  endfunction

  function automatic int offs(input int m, input int i);
    int t1[2] = '{0, 1};
    int t3[4] = '{0, 0, 1, 1};
    case (m)
      1: return t1[i];
      3: return t3[i];
      4: return i;
      default: return 0;
    endcase
  endfunction

  function automatic string tag(input logic [1:0] k);
    case (k)
      2'd0: return "R2";
      2'd1: return "R3/R4/R5/R8";
      default: return "R6/R7";
    endcase
  endfunction

  task automatic push(input logic [1:0] k, input logic we, input logic [23:0] a,
                      input logic [15:0] io, input logic [7:0] d);
    exp_t e;
    e.kind = k; e.we = we; e.a = a; e.io = io; e.d = d;
    q.push_back(e);
  endtask

  task automatic model_frame();
    for (int c = 0; c < N; c++) m_act[c] = 1'b0;
    for (int c = 0; c < N; c++) begin
      if (en_mask[c]) begin
        logic [23:0] a;
        a = cfg_src[c*24 +: 24];
        push(2'd0, 1'b0, a, 16'h0, 8'h0);
        m_lines[c] = int'(rd(a));
        m_ptr[c]   = (int'(a[15:0]) + 1) & 16'hFFFF;
        m_act[c]   = (m_lines[c] != 0);
      end
    end
  endtask

  task automatic model_line();
    for (int c = 0; c < N; c++) begin
      if (en_mask[c] && m_act[c]) begin
        int md, nb;
        logic [7:0] bank, dst;
        logic [23:0] a;
        md   = int'(cfg_mode[c*3 +: 3]);
        nb   = nbytes(md);
        bank = cfg_src[c*24+16 +: 8];
        dst  = cfg_dest[c*8 +: 8];
        for (int i = 0; i < nb; i++) begin
          a = {bank, 16'(m_ptr[c] + i)};
          push(2'd1, 1'b1, a, {8'h21, 8'(int'(dst) + offs(md, i))}, rd(a));
        end
        m_lines[c]--;
        if (m_lines[c] == 0) begin
          a = {bank, 16'(m_ptr[c] + nb)};
          push(2'd2, 1'b0, a, 16'h0, 8'h0);
          m_lines[c] = int'(rd(a));
          m_ptr[c]   = (m_ptr[c] + nb + 1) & 16'hFFFF;
          m_act[c]   = (m_lines[c] != 0);
        end
      end
    end
  endtask

  // reference model and per-cycle comparison
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int c = 0; c < N; c++) m_act[c] = 1'b0;
    end else if (q.size() == 0) begin
      if (frame) model_frame();
      else if (line) model_line();
    end
    #3;
    if (rst_n) begin
      checks++;
      if (q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        if (!mem_rd || !stall || mem_addr !== e.a || io_we !== e.we ||
            (e.we && (io_addr !== e.io || io_data !== e.d))) begin
          fails++;
          $display("FAIL %s: rd=%b stall=%b addr=%h we=%b io=%h d=%h, expected rd=1 stall=1 addr=%h we=%b io=%h d=%h",
                   tag(e.kind), mem_rd, stall, mem_addr, io_we, io_addr, io_data,
                   e.a, e.we, e.io, e.d);
        end
      end else if (mem_rd !== 1'b0 || io_we !== 1'b0 || stall !== 1'b0) begin
        fails++;
        $display("FAIL R1/R9/R10/R11 idle: rd=%b we=%b stall=%b, expected 0 0 0",
                 mem_rd, io_we, stall);
      end
    end
  end

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    mem[{a[15], a[10:0]}] = d;
  endtask

  task automatic pulse_line();
    @(negedge clk) line = 1'b1;
    @(negedge clk) line = 1'b0;
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame = 1'b1;
    @(negedge clk) frame = 1'b0;
  endtask

  task automatic settle();
    repeat (30) @(negedge clk);
  endtask

  task automatic set_ch(input int c, input logic [2:0] m, input logic [7:0] d,
                        input logic [23:0] s);
    cfg_mode[c*3 +: 3]  = m;
    cfg_dest[c*8 +: 8]  = d;
    cfg_src[c*24 +: 24] = s;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    // ch0 mode 000, two-entry table
    put(16'h0100, 8'd2); put(16'h0101, 8'hA1); put(16'h0102, 8'd1);
    put(16'h0103, 8'hA2); put(16'h0104, 8'd0);
    put(16'h0180, 8'd1);
    // ch2 mode 001
    put(16'h0200, 8'd1); put(16'h0201, 8'hB1); put(16'h0202, 8'hB2);
    put(16'h0203, 8'd3); put(16'h0204, 8'hB3); put(16'h0205, 8'hB4);
    put(16'h0206, 8'd0);
    // ch3 mode 011, dest offset wraps in page (R4)
    put(16'h0300, 8'd2); put(16'h0301, 8'hC1); put(16'h0302, 8'hC2);
    put(16'h0303, 8'hC3); put(16'h0304, 8'hC4); put(16'h0305, 8'd0);
    put(16'h0380, 8'd1);
    // ch5 mode 100, values straddle bank top (R8)
    put(16'hFFFC, 8'd1); put(16'hFFFD, 8'hD1); put(16'hFFFE, 8'hD2);
    put(16'hFFFF, 8'hD3); put(16'h0000, 8'hD4); put(16'h0001, 8'd2);
    put(16'h0002, 8'hE1); put(16'h0003, 8'hE2); put(16'h0004, 8'hE3);
    put(16'h0005, 8'hE4); put(16'h0006, 8'd0);
    // ch6 first count zero (R7)
    put(16'h0400, 8'd0);
    // ch7 mode 110 behaves as one byte (R3)
    put(16'h0500, 8'd5); put(16'h0501, 8'hF7);

    set_ch(0, 3'd0, 8'h18, 24'h01_0100);
    set_ch(1, 3'd0, 8'h10, 24'h00_0180);
    set_ch(2, 3'd1, 8'h0D, 24'h00_0200);
    set_ch(3, 3'd3, 8'hFF, 24'h02_0300);
    set_ch(4, 3'd4, 8'h20, 24'h00_0380);
    set_ch(5, 3'd4, 8'h40, 24'h00_FFFC);
    set_ch(6, 3'd2, 8'h22, 24'h00_0400);
    set_ch(7, 3'd6, 8'h30, 24'h03_0500);
    en_mask = 8'b1110_1101;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);   // R1 reset state
    pulse_line();                // R1 line before frame: nothing
    settle();

    pulse_frame();               // R2
    settle();
    pulse_line();                // R3 R4 R5 R8
    settle();
    pulse_line();                // R6 reloads
    repeat (3) @(negedge clk);
    pulse_line();                // R10 ignored while busy
    settle();

    en_mask = 8'b1110_0101;      // R11 ch3 skipped
    pulse_line();
    settle();
    en_mask = 8'b1110_1101;
    for (int k = 0; k < 6; k++) begin
      pulse_line();              // R6 R7 tables run out
      settle();
    end

    @(negedge clk) begin frame = 1'b1; line = 1'b1; end   // R10 frame wins
    @(negedge clk) begin frame = 1'b0; line = 1'b0; end
    settle();
    for (int k = 0; k < 3; k++) begin
      pulse_line();
      settle();
    end
    pulse_frame();
    repeat (2) @(negedge clk);
    pulse_frame();               // R10 frame while busy ignored
    settle();
    pulse_line();
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule